// File: doc/BRIEF.md
# Buffered Frame-Rate Step Pulse Generator

This block turns a queue of velocity commands into motor step signals. A host writes 32-bit command words into a small queue inside the block. The generator takes one word at the start of each frame. A frame is a programmable number of clock cycles, and in each of those cycles a signed rate is added to a 28-bit phase accumulator. Every change of the accumulator's top bit counts as one motor step. Because every frame has a fixed length, the host can work out exactly where the accumulator will stand after any number of queued words. The host only has to keep the queue from running dry, and it can use a half-full flag to decide when to refill it.

A command word may also carry a preset for the accumulator's upper three bits. The preset is applied once, just before the first addition of that word's frame. The host uses it to put the accumulator in a known, safe position, either to discard a fractional step or before a reversal. The output format is fixed for each instance by a parameter. It is either a one-cycle step pulse with a direction level, or a two-bit Gray-coded phase pair. When the generator is switched off, its two pins are driven from a plain output value instead. If the queue is empty at a frame boundary, the generator keeps the last rate and raises a sticky error flag.

Top module: `frame_step_gen`

## Requirements
- R1: A command word holds the rate as a 28-bit two's-complement value in bits 27:0, a preset value in bits 30:28, and a preset-enable flag in bit 31.
- R2: While `gen_en` is high, each frame is `frame_len` accumulator additions long, and a `frame_len` of 0 acts as 1. One word is taken from the queue at every frame boundary. The first enabled cycle after a disabled one always starts a new frame.
- R3: When bit 31 of the word is set, accumulator bits 27:25 are replaced by bits 30:28 of the word once, before the first addition of its frame. The preset is skipped when bit 31 is clear, and it is never applied again on frames that reuse a held rate.
- R4: Every clock in which accumulator bit 27 differs from its value one clock earlier produces exactly one step. The step goes backward when bit 27 of the rate in use is 1, and forward otherwise.
- R5: With `QUAD_MODE`=0, `out_a` is high for one clock per step, and `out_b` shows the sign bit of the rate in use (1 = backward).
- R6: With `QUAD_MODE`=1, the pair {`out_a`,`out_b`} steps through 00, 01, 11, 10 on forward steps and through the reverse order on backward steps. At most one of the two bits changes per clock.
- R7: The queue holds 16 words. A write to a full queue is dropped. `half_full` is high whenever 8 or more words are stored.
- R8: If the queue is empty at a frame boundary, the previous rate is kept and `underrun` is set. The flag stays set until a host write, and a set in the same cycle as a write wins.
- R9: While `gen_en` is low, `out_a` follows `gpo_val[0]` and `out_b` follows `gpo_val[1]`. The accumulator, the rate and the quadrature position are held during that time.
- R10: After reset, `underrun` and `half_full` are 0, the accumulator is 0, and the quadrature phase is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one accumulator addition per cycle while generating |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe into the command queue |
| wr_data | input | 32 | Command word (rate, preset value, preset enable) |
| frame_len | input | FRAME_W | Additions per command word |
| gen_en | input | 1 | 1 = generate steps, 0 = pins follow `gpo_val` |
| gpo_val | input | 2 | Plain output values used while generation is off |
| half_full | output | 1 | Queue holds at least half its capacity |
| underrun | output | 1 | Sticky: a frame began with an empty queue |
| out_a | output | 1 | Step pulse, or phase bit A |
| out_b | output | 1 | Direction, or phase bit B |

## Verification
The assertions watch, on every clock, that the quadrature pair never changes two bits at once and that the underrun flag is sticky and rises only while generating. They also check that half-full rises only after a write and that the accumulator is frozen while generation is off. Step counts, step directions, preset effects, the dropping of writes to a full queue, and the held rate after an underrun cannot be seen from one cycle. Only the bench's scenarios show these, by comparing the total of observed pulses against an arithmetic model over sweeps of frame length.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  parameter int unsigned ACC_W  = 28;
  parameter int unsigned PRE_W  = 3;
  parameter int unsigned WORD_W = ACC_W + PRE_W + 1;

  // Command word layout: {preset enable, preset value, signed rate}
  typedef struct packed {
    logic             pre_ok;
    logic [PRE_W-1:0] pre_val;
    logic [ACC_W-1:0] rate;
  } ctrl_word_t;

  // 2-bit position to Gray-coded phase pair {a,b}
  function automatic logic [1:0] quad_phase(input logic [1:0] pos);
    return {pos[1], pos[1] ^ pos[0]};
  endfunction
endpackage

// File: rtl/fsg_fifo.sv
module fsg_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             half_full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push, pop;

  always_comb begin
    push     = wr_en && (cnt_q != FULL_CNT);
    pop      = rd_en && (cnt_q != '0);
    wr_ptr_d = push ? wr_ptr_q + 1'b1 : wr_ptr_q;
    rd_ptr_d = pop ? rd_ptr_q + 1'b1 : rd_ptr_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= wr_data;
    end
  end

  assign rd_data   = mem[rd_ptr_q];
  assign empty     = (cnt_q == '0);
  assign half_full = (cnt_q >= HALF_CNT);
endmodule

// File: rtl/fsg_frame_engine.sv
module fsg_frame_engine import fsg_pkg::*; #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic               word_valid,
  input  ctrl_word_t         word,
  input  logic               host_wr,
  output logic               pop,
  output logic [ACC_W-1:0]   acc,
  output logic [ACC_W-1:0]   rate,
  output logic               underrun
);
  localparam int unsigned PRE_LSB = ACC_W - PRE_W;

  logic [FRAME_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0]   acc_q, acc_d, rate_q, rate_d, base;
  logic               und_q, und_d;
  logic               boundary, starve;

  always_comb begin
    boundary = (cnt_q == '0);
    pop      = run && boundary && word_valid;
    starve   = run && boundary && !word_valid;
    base     = acc_q;
    if (pop && word.pre_ok) begin
      base[ACC_W-1:PRE_LSB] = word.pre_val;
    end
    rate_d = pop ? word.rate : rate_q;
    acc_d  = base + rate_d;
    if (!run) begin
      cnt_d = '0;
    end else if (boundary) begin
      cnt_d = (frame_len == '0) ? '0 : frame_len - 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    if (starve) begin
      und_d = 1'b1;
    end else if (host_wr) begin
      und_d = 1'b0;
    end else begin
      und_d = und_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      rate_q <= '0;
      und_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      und_q <= und_d;
      if (run) begin
        acc_q  <= acc_d;
        rate_q <= rate_d;
      end
    end
  end

  assign acc      = acc_q;
  assign rate     = rate_q;
  assign underrun = und_q;
endmodule

// File: rtl/fsg_step_out.sv
module fsg_step_out import fsg_pkg::*; #(
  parameter bit QUAD_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_msb,
  input  logic rate_neg,
  output logic pin_a,
  output logic pin_b
);
  logic msb_q;
  logic toggle;

  assign toggle = acc_msb ^ msb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= 1'b0;
    end else begin
      msb_q <= acc_msb;
    end
  end

  generate
    if (QUAD_MODE) begin : g_quad
      logic [1:0] pos_q, pos_d;
      always_comb begin
        pos_d = pos_q;
        if (toggle) begin
          pos_d = rate_neg ? pos_q - 2'd1 : pos_q + 2'd1;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pos_q <= 2'b00;
        end else if (toggle) begin
          pos_q <= pos_d;
        end
      end
      assign {pin_a, pin_b} = quad_phase(pos_q);
    end else begin : g_step_dir
      logic step_q, dir_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          step_q <= 1'b0;
          dir_q  <= 1'b0;
        end else begin
          step_q <= toggle;
          dir_q  <= rate_neg;
        end
      end
      assign pin_a = step_q;
      assign pin_b = dir_q;
    end
  endgenerate
endmodule

// File: rtl/frame_step_gen.sv
module frame_step_gen import fsg_pkg::*; #(
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter bit          QUAD_MODE  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic               gen_en,
  input  logic [1:0]         gpo_val,
  output logic               half_full,
  output logic               underrun,
  output logic               out_a,
  output logic               out_b
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [WORD_W-1:0] head_raw;
  ctrl_word_t        head_word;
  logic              q_empty, q_pop;
  logic [ACC_W-1:0]  acc_q, rate_q;
  logic              core_a, core_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  fsg_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (q_pop),
    .rd_data   (head_raw),
    .empty     (q_empty),
    .half_full (half_full)
  );

  assign head_word = ctrl_word_t'(head_raw);

  fsg_frame_engine #(.FRAME_W(FRAME_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (gen_en),
    .frame_len  (frame_len),
    .word_valid (!q_empty),
    .word       (head_word),
    .host_wr    (wr_en),
    .pop        (q_pop),
    .acc        (acc_q),
    .rate       (rate_q),
    .underrun   (underrun)
  );

  fsg_step_out #(.QUAD_MODE(QUAD_MODE)) u_pins (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc_msb  (acc_q[ACC_W-1]),
    .rate_neg (rate_q[ACC_W-1]),
    .pin_a    (core_a),
    .pin_b    (core_b)
  );

  assign out_a = gen_en ? core_a : gpo_val[0];
  assign out_b = gen_en ? core_b : gpo_val[1];
endmodule

// File: rtl/frame_step_gen_chk.sv
module frame_step_gen_chk #(
  parameter bit          QUAD_MODE = 1'b0,
  parameter int unsigned ACC_W     = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             wr_en,
  input logic             out_a,
  input logic             out_b,
  input logic             half_full,
  input logic             underrun,
  input logic [ACC_W-1:0] acc
);
  AST_QUAD_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (QUAD_MODE && gen_en && $past(gen_en)) |-> ($countones({out_a, out_b} ^ $past({out_a, out_b})) <= 1)); // R6

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !wr_en) |=> underrun); // R8

  AST_UNDERRUN_RISE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(gen_en)); // R8

  AST_HALF_FULL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_full) |-> $past(wr_en)); // R7

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> $stable(acc)); // R9
endmodule

bind frame_step_gen frame_step_gen_chk #(.QUAD_MODE(QUAD_MODE), .ACC_W(fsg_pkg::ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .gen_en    (gen_en),
  .wr_en     (wr_en),
  .out_a     (out_a),
  .out_b     (out_b),
  .half_full (half_full),
  .underrun  (underrun),
  .acc       (acc_q)
);

// File: tb/frame_step_gen_tb.sv
module frame_step_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [15:0] frame_len;
  logic        gen_en;
  logic [1:0]  gpo_val;
  logic        hf_sd, ur_sd, a_sd, b_sd;
  logic        hf_q, ur_q, a_q, b_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [27:0] m_acc = '0;
  logic        m_msb = 1'b0;
  int          m_steps = 0;
  int          m_net   = 0;
  int          obs_steps = 0;
  int          obs_net   = 0;

  always #10 clk = ~clk;

  frame_step_gen #(.QUAD_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .frame_len(frame_len),
    .gen_en(gen_en), .gpo_val(gpo_val), .half_full(hf_sd), .underrun(ur_sd),
    .out_a(a_sd), .out_b(b_sd));

  frame_step_gen #(.QUAD_MODE(1'b1)) u_dut_quad (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .frame_len(frame_len),
    .gen_en(gen_en), .gpo_val(gpo_val), .half_full(hf_q), .underrun(ur_q),
    .out_a(a_q), .out_b(b_q));

  always @(negedge clk) begin
    if (gen_en && a_sd) begin
      obs_steps++;
      obs_net += b_sd ? -1 : 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit pv, input int pre, input bit neg, input int mag);
    logic [27:0] r;
    r = 28'(mag);
    if (neg) r = -r;
    return {pv, 3'(pre), r};
  endfunction

  task automatic model_word(input logic [31:0] w, input int len);
    int n;
    n = (len == 0) ? 1 : len;
    if (w[31]) m_acc[27:25] = w[30:28];
    for (int k = 0; k < n; k++) begin
      m_acc = m_acc + w[27:0];
      if (m_acc[27] != m_msb) begin
        m_steps++;
        m_net += w[27] ? -1 : 1;
      end
      m_msb = m_acc[27];
    end
  endtask

  function automatic int exp_phase();
    int pos;
    pos = m_net & 3;
    return (((pos >> 1) & 1) << 1) | (((pos >> 1) ^ pos) & 1);
  endfunction

  task automatic push(input logic [31:0] w);
    wr_en = 1'b1;
    wr_data = w;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic check_totals(input string tag);
    chk("R2 R3 R4", {tag, " step count"}, obs_steps, m_steps);
    chk("R1 R4 R5", {tag, " net position"}, obs_net, m_net);
  endtask

  task automatic run_en(input int n, input int dir_exp, input string tag);
    gen_en = 1'b1;
    for (int p = 1; p <= n; p++) begin
      @(posedge clk); #1;
      if (p == 3 && dir_exp >= 0) chk("R5", {tag, " direction pin"}, int'(b_sd), dir_exp);
    end
    chk("R6", {tag, " quadrature phase"}, int'({a_q, b_q}), exp_phase());
    gen_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int lens[6];
    lens = '{1, 2, 4, 7, 16, 0};
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; frame_len = 16'd3; gen_en = 1'b0; gpo_val = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // Reset state (R10)
    chk("R10", "underrun after reset", int'(ur_sd), 0);
    chk("R10", "half_full after reset", int'(hf_sd), 0);
    gen_en = 1'b1; #2;
    chk("R10", "quadrature phase after reset", int'({a_q, b_q}), 0);
    gen_en = 1'b0; #2;

    // Plain outputs while disabled (R9)
    for (int v = 0; v < 4; v++) begin
      gpo_val = 2'(v); #2;
      chk("R9", "step/dir pins follow gpo", int'({b_sd, a_sd}), v);
      chk("R9", "quad pins follow gpo", int'({b_q, a_q}), v);
    end
    gpo_val = 2'b00;
    @(posedge clk); #1;

    // Fill sweep: half-full level and drop on full (R7); 16 words at frame length 3
    frame_len = 16'd3;
    for (int i = 0; i < 16; i++) begin
      if (i == 15) w = mk(1'b0, 0, 1'b0, 0);
      else w = mk((i % 4) == 1, i & 7, (i % 3) == 0, 32'h0150000 + i * 32'h0031000);
      push(w);
      model_word(w, 3);
      chk("R7", $sformatf("half_full after %0d writes", i + 1), int'(hf_sd), (i + 1 >= 8) ? 1 : 0);
    end
    push(mk(1'b0, 0, 1'b0, 32'h4000000)); // dropped: queue full
    chk("R7", "half_full stays set after write to full queue", int'(hf_sd), 1);
    run_en(16 * 3 + 10, 1, "S1");
    check_totals("S1 R7 dropped write");
    chk("R7", "S1 half_full after drain", int'(hf_sd), 0);
    chk("R8", "S1 underrun after drain", int'(ur_sd), 1);

    // Frame length sweep (R2, R3, R9 state held across disabled gaps)
    foreach (lens[li]) begin
      int L;
      L = lens[li];
      frame_len = 16'(L);
      for (int i = 0; i < 6; i++) begin
        if (i == 5) w = mk(1'b0, 0, 1'b0, 0);
        else w = mk(i == 2, L & 7, ((i + L) % 2) == 1, 32'h0400000 + L * 32'h0013579 + i * 32'h0051234);
        push(w);
        model_word(w, L);
      end
      chk("R8", $sformatf("L=%0d underrun cleared by write", L), int'(ur_sd), 0);
      run_en(6 * ((L == 0) ? 1 : L) + 8, (L >= 2) ? (L % 2) : -1, $sformatf("S2 L=%0d", L));
      check_totals($sformatf("S2 L=%0d R9", L));
      chk("R8", $sformatf("L=%0d underrun at end", L), int'(ur_sd), 1);
    end

    // Held rate after underrun; preset not reapplied (R3, R8)
    frame_len = 16'd5;
    w = mk(1'b1, 4, 1'b0, 32'h0A00000);
    push(w);
    chk("R8", "S3 underrun cleared by write", int'(ur_sd), 0);
    model_word(w, 5);
    for (int f = 0; f < 4; f++) model_word({1'b0, w[30:0]}, 5);
    model_word(32'h0, 5);
    gen_en = 1'b1;
    for (int p = 1; p <= 40; p++) begin
      @(posedge clk); #1;
      if (p == 21) begin
        chk("R8", "S3 underrun set on empty boundary", int'(ur_sd), 1);
        wr_en = 1'b1; wr_data = 32'h0;
      end
      if (p == 22) begin
        wr_en = 1'b0;
        chk("R8", "S3 underrun cleared mid-frame by write", int'(ur_sd), 0);
      end
    end
    chk("R6", "S3 quadrature phase", int'({a_q, b_q}), exp_phase());
    gen_en = 1'b0;
    check_totals("S3 R3 R8 held rate");
    chk("R8", "S3 underrun at end", int'(ur_sd), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule